// File: doc/BRIEF.md
# Three-Channel Match and Overflow Timer

This peripheral holds three independent 32-bit counters behind a small word-addressed register port. Every channel has a live count, a reload value and two compare values. Each enabled channel steps once per tick, either upward or downward. A tick is every bus clock cycle, or each rising edge of an external clock after that edge is synchronised. When a channel wraps, it takes its reload value and may flag an overflow. When a step lands on one of its compare values, it flags a match.

The nine event flags (three per channel) are gathered in one status register and cleared by writing ones. A mask register with the same bit layout decides which flags reach the single interrupt line. Software builds a periodic tick by loading a reload value P steps below the top of an up-counting range. It builds a one-shot by writing the current count plus a delay into the first compare register.

Top module: `tri_timer`

## Requirements
- R1: After reset every count, reload, compare and control register reads 0, status reads 0, the mask reads 0x1FF and irq is low.
- R2: Channel n (0..2) places count at byte offset 0x10*n, reload at +0x4, compare A at +0x8 and compare B at +0xC. Control is at 0x30, status at 0x34 and mask at 0x38. Control reads back its low 12 bits, and status and mask read back their low 9 bits, with the upper bits 0.
- R3: With control bit 3n (enable) set, bit 3n+1 (external clock select) clear and bit 9+n (direction) set, channel n counts up by one every clock.
- R4: With its enable bit clear, a channel holds its count.
- R5: An up-counting channel at 0xFFFFFFFF reloads from its reload register on its next tick. It sets status bit 3n+2 when control bit 3n+2 (overflow enable) is set, so a reload of 0xFFFFFFFF-(P-1) flags an overflow every P ticks.
- R6: With direction bit 9+n clear, a channel counts down, and a tick at 0 loads the reload value and flags overflow under the same overflow-enable rule as R5.
- R7: A tick that moves channel n's count onto compare A sets status bit 3n, and one that moves it onto compare B sets status bit 3n+1.
- R8: A write to status clears exactly the bits written as 1; a write of 0 leaves status unchanged; status bits otherwise stay set.
- R9: irq is high exactly when some status bit is set whose mask bit is 0; status is recorded whatever the mask.
- R10: With the clock select bit set, the channel steps once per rising edge of ext_clk and not on the bus clock.
- R11: A software write to a count register takes effect on the next clock edge even while the channel runs, overriding that edge's step.
- R12: With overflow enable clear, a wrap still reloads the count but leaves status bit 3n+2 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External count clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The assertions take for granted that each access is word-aligned, and that writes touching a channel's count or the status register show up on wr_en and addr in the same cycle as the edge that commits them. They also take for granted that ext_clk is slow enough for every level to be sampled at least twice. The stimulus holds every strobe for exactly one clock, keeps addresses aligned, and holds ext_clk high and low for three clocks at a time. Compare values are parked far away from the count when a test does not target matches, so no stray match flag disturbs the status checks.

// File: rtl/tri_timer.sv
module tri_timer #(
  parameter int CW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam int NCH  = 3;
  localparam int NEV  = 3 * NCH;
  localparam int CTLW = 4 * NCH;
  localparam int NREG = 4 * NCH + 3;

  logic [NCH-1:0][CW-1:0] cnt_q, rld_q, ma_q, mb_q;
  logic [CTLW-1:0] ctl_q;
  logic [NEV-1:0]  st_q, msk_q, ev;
  logic [2:0]      sync_q;
  logic            ext_tick, addr_ok;
  logic [NREG-1:0] wsel;

  assign addr_ok  = (addr[AW-1:6] == '0) && (addr[1:0] == 2'b00);
  assign wsel     = (wr_en && addr_ok) ? NREG'(1 << addr[5:2]) : '0;
  assign ext_tick = sync_q[1] & ~sync_q[2];
  assign irq      = |(st_q & ~msk_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_clk};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic en, sel, oie, up, tick, wrap, cwr;
    logic [CW-1:0] nxt;
    assign en   = ctl_q[3*g];
    assign sel  = ctl_q[3*g+1];
    assign oie  = ctl_q[3*g+2];
    assign up   = ctl_q[3*NCH+g];
    assign cwr  = wsel[4*g];
    assign tick = en & (sel ? ext_tick : 1'b1) & ~cwr;
    assign wrap = up ? (&cnt_q[g]) : (cnt_q[g] == '0);
    assign nxt  = wrap ? rld_q[g] : (up ? cnt_q[g] + 1'b1 : cnt_q[g] - 1'b1);
    assign ev[3*g]   = tick & (nxt == ma_q[g]);
    assign ev[3*g+1] = tick & (nxt == mb_q[g]);
    assign ev[3*g+2] = tick & wrap & oie;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt_q[g] <= '0;
        rld_q[g] <= '0;
        ma_q[g]  <= '0;
        mb_q[g]  <= '0;
      end else begin
        if (cwr)             cnt_q[g] <= wdata;
        else if (tick)       cnt_q[g] <= nxt;
        if (wsel[4*g+1])     rld_q[g] <= wdata;
        if (wsel[4*g+2])     ma_q[g]  <= wdata;
        if (wsel[4*g+3])     mb_q[g]  <= wdata;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_q <= '0;
      st_q  <= '0;
      msk_q <= '1;
    end else begin
      if (wsel[4*NCH])   ctl_q <= wdata[CTLW-1:0];
      if (wsel[4*NCH+2]) msk_q <= wdata[NEV-1:0];
      st_q <= (st_q & ~(wsel[4*NCH+1] ? wdata[NEV-1:0] : '0)) | ev;
    end

  always_comb begin
    rdata = '0;
    if (addr_ok) begin
      if (addr[5:4] == 2'b11) begin
        case (addr[3:2])
          2'd0:    rdata[CTLW-1:0] = ctl_q;
          2'd1:    rdata[NEV-1:0]  = st_q;
          2'd2:    rdata[NEV-1:0]  = msk_q;
          default: rdata = '0;
        endcase
      end else begin
        for (int c = 0; c < NCH; c++)
          if (addr[5:4] == c[1:0])
            case (addr[3:2])
              2'd0:    rdata = cnt_q[c];
              2'd1:    rdata = rld_q[c];
              2'd2:    rdata = ma_q[c];
              default: rdata = mb_q[c];
            endcase
      end
    end
  end
endmodule

module tri_timer_chk #(
  parameter int CW = 32,
  parameter int AW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [AW-1:0]       addr,
  input logic [2:0][CW-1:0]  cnt,
  input logic [11:0]         ctl,
  input logic [8:0]          st,
  input logic [8:0]          msk,
  input logic                irq
);
  logic st_wr;
  assign st_wr = wr_en && (addr == AW'(8'h34));

  for (genvar g = 0; g < 3; g++) begin : g_c
    logic cw;
    assign cw = wr_en && (addr == AW'(16 * g));
    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[3*g] && !cw) |=> $stable(cnt[g]));
    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[3*g] && !ctl[3*g+1] && ctl[9+g] && !cw && cnt[g] != '1)
        |=> cnt[g] == CW'($past(cnt[g]) + 1'b1));
    // R6
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[3*g] && !ctl[3*g+1] && !ctl[9+g] && !cw && cnt[g] != '0)
        |=> cnt[g] == CW'($past(cnt[g]) - 1'b1));
  end

  for (genvar i = 0; i < 9; i++) begin : g_s
    // R8
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[i] && !st_wr) |=> st[i]);
  end

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk) |-> !irq);
endmodule

bind tri_timer tri_timer_chk #(.CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .cnt(cnt_q), .ctl(ctl_q), .st(st_q), .msk(msk_q), .irq(irq));

// File: tb/tri_timer_tb.sv
module tri_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTL = 8'h30, STS = 8'h34, MSK = 8'h38;

  logic clk = 0, rst_n = 0, ext_clk = 0, wr_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  tri_timer dut_i (.clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int n);
    logic [7:0] cb;
    cb = 8'(16 * n);
    wr(CTL, 0);
    wr(cb, 0); wr(cb + 8'h4, 0);
    wr(cb + 8'h8, 32'h8000_0000); wr(cb + 8'hC, 32'h8000_0001);
    wr(STS, 32'h1FF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, en, up, oie, L;
    logic [7:0] cb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    waitc(1);

    // R1 reset state
    for (int a = 0; a < 15; a++) begin
      rd(8'(4 * a), v);
      chk("R1 reset value", v, (a == 14) ? 32'h1FF : 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2 register map sweep
    for (int n = 0; n < 3; n++)
      for (int k = 1; k < 4; k++) begin
        cb = 8'(16 * n + 4 * k);
        wr(cb, 32'hA5000000 | 32'(n << 8) | 32'(k));
        rd(cb, v);
        chk("R2 channel register readback", v, 32'hA5000000 | 32'(n << 8) | 32'(k));
      end
    wr(CTL, 32'hFFFF_F000 | 32'h0); rd(CTL, v); chk("R2 control upper bits", v, 0);
    wr(MSK, 32'hFFFF_FE00); rd(MSK, v); chk("R2 mask width", v, 0);
    wr(MSK, 32'hFFFF_FFFF); rd(MSK, v); chk("R2 mask width", v, 32'h1FF);

    for (int n = 0; n < 3; n++) begin
      cb  = 8'(16 * n);
      en  = 32'(1) << (3 * n);
      oie = 32'(1) << (3 * n + 2);
      up  = 32'(1) << (9 + n);

      // R3 / R4
      setup(n);
      wr(cb, 100);
      wr(CTL, en | up);
      wr(CTL, en | up); // rewrite: one edge elapsed while enabled
      waitc(4 + n);
      rd(cb, v); chk("R3 up count", v, 32'(100 + 5 + n));
      wr(CTL, 0);
      rd(cb, v); chk("R4 stop edge", v, 32'(100 + 6 + n));
      waitc(7);
      rd(cb, v); chk("R4 hold while disabled", v, 32'(100 + 6 + n));

      // R6 down count with wrap
      setup(n);
      wr(cb + 8'h4, 50); wr(cb, 3);
      wr(CTL, en | oie);
      waitc(3);
      rd(cb, v);  chk("R6 down to zero", v, 0);
      rd(STS, v); chk("R6 no early overflow", v, 0);
      waitc(1);
      rd(cb, v);  chk("R6 wrap to reload", v, 50);
      rd(STS, v); chk("R6 overflow flag", v, oie);
      waitc(1);
      rd(cb, v);  chk("R6 decrement after reload", v, 49);

      // R5 periodic overflow, R12 without enable
      for (int e = 0; e < 2; e++) begin
        setup(n);
        L = 32'hFFFF_FFFF - 32'(3 + n - 1);
        wr(cb + 8'h4, L); wr(cb, L);
        wr(CTL, en | up | (e == 0 ? oie : 32'h0));
        waitc(3 + n - 1);
        rd(cb, v);  chk("R5 reaches top", v, 32'hFFFF_FFFF);
        rd(STS, v); chk("R5 no early overflow", v, 0);
        waitc(1);
        rd(cb, v);  chk(e == 0 ? "R5 reload on wrap" : "R12 reload on wrap", v, L);
        rd(STS, v);
        if (e == 0) chk("R5 overflow every P ticks", v, oie);
        else        chk("R12 overflow suppressed", v, 0);
      end

      // R7 matches
      setup(n);
      wr(cb, 10); wr(cb + 8'h8, 13); wr(cb + 8'hC, 16);
      wr(CTL, en | up);
      waitc(2);
      rd(STS, v); chk("R7 no early match", v, 0);
      waitc(1);
      rd(STS, v); chk("R7 compare A", v, 32'(1) << (3 * n));
      waitc(3);
      rd(STS, v); chk("R7 compare B", v, 32'(3) << (3 * n));
      wr(CTL, 0);

      // R8 write-one-to-clear
      wr(STS, 32'(1) << (3 * n));
      rd(STS, v); chk("R8 clear selected bit", v, 32'(1) << (3 * n + 1));
      wr(STS, 0);
      rd(STS, v); chk("R8 zero write no effect", v, 32'(1) << (3 * n + 1));

      // R9 mask sweep
      chk("R9 all masked", {31'b0, irq}, 0);
      for (int b = 0; b < 9; b++) begin
        wr(MSK, 32'h1FF & ~(32'(1) << b));
        chk("R9 irq vs mask", {31'b0, irq}, (b == 3 * n + 1) ? 1 : 0);
      end
      wr(MSK, 32'h1FF);
      rd(STS, v); chk("R9 status kept under mask", v, 32'(1) << (3 * n + 1));

      // R10 external clock
      setup(n);
      wr(CTL, en | up | (32'(1) << (3 * n + 1)));
      waitc(5);
      rd(cb, v); chk("R10 idle external clock", v, 0);
      for (int p = 0; p < 4 + n; p++) begin
        ext_clk = 1; waitc(3);
        ext_clk = 0; waitc(3);
      end
      waitc(4);
      rd(cb, v); chk("R10 one step per edge", v, 32'(4 + n));

      // R11 direct count write while running
      setup(n);
      wr(CTL, en | up);
      waitc(3);
      wr(cb, 32'h1000);
      rd(cb, v); chk("R11 write overrides step", v, 32'h1000);
      waitc(2);
      rd(cb, v); chk("R11 counts on from written value", v, 32'h1002);
      wr(CTL, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule